// File: doc/BRIEF.md
# Interrupt Acceptance History Log

This block keeps a circular record of the interrupts that a processor core has accepted. Each interrupt request line has its own timestamp register. Every cycle in which a line's request is asserted, that register loads the current value of the free-running cycle counter. The register therefore always holds the most recent time the line was raised.

When the core accepts an interrupt, it pulses an accept strobe together with the line number. The block then writes one log entry into the slot under its write pointer and advances the pointer, wrapping at the end of the buffer. The entry holds the line number, the current cycle as the taken time, and the line's stored raised time. A free-running counter tallies every acceptance.

A debug agent reads the log through a combinational port indexed by age. Position 0 is the newest entry, position 1 the one before it, and so on. For each position the port returns:
- the entry's fields;
- a valid flag;
- the entry's latency (taken minus raised);
- the gap between its taken time and the next older entry's taken time.

A taken time of zero marks a slot that has never been written, so the bench keeps the cycle counter nonzero once logging starts.

Top module: `irq_history_log`

## Requirements
- R1: For each line, every cycle in which its raise bit is 1 loads that line's timestamp with `cycle_i` at the clock edge, and a later raise overwrites an earlier one. A cycle with the bit at 0 leaves the timestamp unchanged.
- R2: On an edge with `take_i` = 1, the slot under the write pointer receives: id = `take_id_i`, taken = `cycle_i`, and raised = the line's timestamp as it stood before that edge. A raise of the same line in the same cycle is not seen by that entry.
- R3: Each acceptance advances the write pointer by one, returning to slot 0 after slot DEPTH-1. Once the buffer is full, the oldest entry is overwritten.
- R4: `accept_cnt_o` rises by one on each acceptance and wraps modulo 2^CNT_W.
- R5: A synchronous active-high `rst` clears all entries, all line timestamps, the write pointer and the acceptance counter.
- R6: Readout position k (0 to DEPTH-1) returns, without a clock edge, the entry written by the (k+1)-th most recent acceptance.
- R7: `rd_valid_o` is 1 exactly when the addressed entry's taken time is nonzero. A never-written entry reads with all fields 0 and valid 0.
- R8: `rd_latency_o` equals taken minus raised of the addressed entry, modulo 2^32.
- R9: `rd_gap_o` equals the addressed entry's taken time minus the taken time at position k+1, modulo 2^32. It reads 0 when k = DEPTH-1 or either entry is invalid.
- R10: Cycles without `take_i` leave every log entry, the pointer and the counter unchanged, whatever the raise bits do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_i | input | 32 | Current cycle count |
| raise_i | input | 8 | Per-line request asserted this cycle |
| take_i | input | 1 | An interrupt is accepted this cycle |
| take_id_i | input | 3 | Line number of the accepted interrupt |
| rd_pos_i | input | 4 | Readout position, 0 = newest |
| rd_id_o | output | 3 | Line number of the addressed entry |
| rd_taken_o | output | 32 | Taken cycle of the addressed entry |
| rd_raised_o | output | 32 | Raised cycle of the addressed entry |
| rd_valid_o | output | 1 | Addressed entry holds history |
| rd_latency_o | output | 32 | Taken minus raised |
| rd_gap_o | output | 32 | Taken minus next older taken |
| accept_cnt_o | output | 16 | Total acceptances, wrapping |

## Verification
The bench targets four corner cases:
- **Acceptance in the same cycle as a new raise of the same line.** A design that forwards the fresh timestamp reports a latency of zero instead of the time since the earlier raise.
- **Filling the buffer past its depth.** A pointer that saturates or skips a slot shows stale or duplicated entries at the oldest positions.
- **Reading positions beyond the written history, and the last position.** Here a wrong valid flag or gap exposes uninitialised slots or a wrap into the newest entry.
- **Acceptance counter wrap, and raises with no accept strobe.** A counter that saturates, or a log that reacts to raises alone, gives readout values that differ from the expected ones.

// File: rtl/ihb_pkg.sv
package ihb_pkg;

    localparam int CYC_W = 32;
    localparam int LINES = 8;
    localparam int ID_W  = $clog2(LINES);

    typedef logic [CYC_W-1:0] cyc_t;
    typedef logic [ID_W-1:0]  id_t;

    typedef struct packed {
        id_t  id;
        cyc_t taken;
        cyc_t raised;
    } entry_t;

    // Modular difference between two cycle stamps
    function automatic cyc_t cyc_delta(cyc_t later, cyc_t earlier);
        return later - earlier;
    endfunction

endpackage

// File: rtl/ihb_stamp_bank.sv
module ihb_stamp_bank
    import ihb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cyc_t             cycle_i,
    input  logic [LINES-1:0] raise_i,
    input  id_t              sel_i,
    output cyc_t             sel_stamp_o
);

    cyc_t stamp_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                stamp_q[g] <= '0;
            end else if (raise_i[g]) begin
                stamp_q[g] <= cycle_i;
            end
        end

        AST_STAMP_LOAD: assert property (@(posedge clk) disable iff (rst)
            raise_i[g] |=> stamp_q[g] == $past(cycle_i));              // R1
        AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (rst)
            !raise_i[g] |=> $stable(stamp_q[g]));                       // R1
    end

    // Stamp as held before this edge: same-cycle raise is not forwarded
    assign sel_stamp_o = stamp_q[sel_i];

endmodule

// File: rtl/ihb_ring.sv
module ihb_ring
    import ihb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_i,
    input  entry_t           take_entry_i,
    output entry_t           log_o [DEPTH],
    output logic [IDX_W-1:0] head_o,
    output logic [CNT_W-1:0] cnt_o
);

    entry_t           log_q [DEPTH];
    logic [IDX_W-1:0] head_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                log_q[i] <= '0;
            end
            head_q <= '0;
            cnt_q  <= '0;
        end else if (take_i) begin
            log_q[head_q] <= take_entry_i;
            head_q        <= (head_q == IDX_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
            cnt_q         <= cnt_q + 1'b1;
        end
    end

    assign log_o  = log_q;
    assign head_o = head_q;
    assign cnt_o  = cnt_q;

    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (rst)
        take_i |=> head_q == IDX_W'($past(head_q) + 1'b1));             // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        take_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));               // R4
    AST_SLOT_WRITE: assert property (@(posedge clk) disable iff (rst)
        take_i |=> log_q[$past(head_q)] == $past(take_entry_i));        // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> $stable(head_q) && $stable(cnt_q));                 // R10
    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> head_q == '0 && cnt_q == '0);                           // R5

endmodule

// File: rtl/ihb_readout.sv
module ihb_readout
    import ihb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  entry_t           log_i [DEPTH],
    input  logic [IDX_W-1:0] head_i,
    input  logic [IDX_W-1:0] pos_i,
    output id_t              id_o,
    output cyc_t             taken_o,
    output cyc_t             raised_o,
    output logic             valid_o,
    output cyc_t             latency_o,
    output cyc_t             gap_o
);

    logic [IDX_W-1:0] slot_new;
    logic [IDX_W-1:0] slot_old;
    entry_t           newer;
    cyc_t             older_taken;
    logic             older_ok;

    always_comb begin
        // Depth is a power of two, so truncation gives the modulo
        slot_new    = head_i - pos_i - IDX_W'(1);
        slot_old    = slot_new - IDX_W'(1);
        newer       = log_i[slot_new];
        older_taken = log_i[slot_old].taken;
        valid_o     = (newer.taken != '0);
        older_ok    = (pos_i != IDX_W'(DEPTH - 1)) && (older_taken != '0);
        id_o        = newer.id;
        taken_o     = newer.taken;
        raised_o    = newer.raised;
        latency_o   = valid_o ? cyc_delta(newer.taken, newer.raised) : '0;
        gap_o       = (valid_o && older_ok) ? cyc_delta(newer.taken, older_taken) : '0;
    end

endmodule

// File: rtl/irq_history_log.sv
module irq_history_log
    import ihb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      cycle_i,
    input  logic [7:0]       raise_i,
    input  logic             take_i,
    input  logic [2:0]       take_id_i,
    input  logic [IDX_W-1:0] rd_pos_i,
    output logic [2:0]       rd_id_o,
    output logic [31:0]      rd_taken_o,
    output logic [31:0]      rd_raised_o,
    output logic             rd_valid_o,
    output logic [31:0]      rd_latency_o,
    output logic [31:0]      rd_gap_o,
    output logic [CNT_W-1:0] accept_cnt_o
);

    cyc_t             line_stamp;
    entry_t           new_entry;
    entry_t           log_w [DEPTH];
    logic [IDX_W-1:0] head_w;

    ihb_stamp_bank u_stamps (
        .clk        (clk),
        .rst        (rst),
        .cycle_i    (cycle_i),
        .raise_i    (raise_i),
        .sel_i      (take_id_i),
        .sel_stamp_o(line_stamp)
    );

    always_comb begin
        new_entry.id     = take_id_i;
        new_entry.taken  = cycle_i;
        new_entry.raised = line_stamp;
    end

    ihb_ring #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ring (
        .clk         (clk),
        .rst         (rst),
        .take_i      (take_i),
        .take_entry_i(new_entry),
        .log_o       (log_w),
        .head_o      (head_w),
        .cnt_o       (accept_cnt_o)
    );

    ihb_readout #(.DEPTH(DEPTH)) u_read (
        .log_i    (log_w),
        .head_i   (head_w),
        .pos_i    (rd_pos_i),
        .id_o     (rd_id_o),
        .taken_o  (rd_taken_o),
        .raised_o (rd_raised_o),
        .valid_o  (rd_valid_o),
        .latency_o(rd_latency_o),
        .gap_o    (rd_gap_o)
    );

    AST_NEWEST_SEEN: assert property (@(posedge clk) disable iff (rst)
        (take_i && rd_pos_i == '0) ##1 (rd_pos_i == '0)
            |-> rd_taken_o == $past(cycle_i));                           // R6

endmodule

// File: tb/tb_irq_history_log.sv
module tb_irq_history_log;

    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int CNT_W  = 16;
    localparam int NVEC   = 12;

    // Vector: {raise[7:0], take, id[2:0]}
    localparam logic [11:0] VEC [NVEC] = '{
        {8'b0000_0001, 1'b0, 3'd0},
        {8'b0000_0100, 1'b0, 3'd0},
        {8'b0000_0000, 1'b1, 3'd0},
        {8'b1000_0000, 1'b1, 3'd2},
        {8'b0000_0000, 1'b0, 3'd0},
        {8'b0000_0000, 1'b1, 3'd7},
        {8'b0000_0001, 1'b0, 3'd0},
        {8'b0011_0000, 1'b1, 3'd0},
        {8'b0000_0000, 1'b1, 3'd5},
        {8'b0000_0000, 1'b1, 3'd4},
        {8'b0000_0010, 1'b0, 3'd0},
        {8'b0000_0000, 1'b1, 3'd3}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cycle_i;
    logic [7:0]  raise_i;
    logic        take_i;
    logic [2:0]  take_id_i;
    logic [3:0]  rd_pos_i;
    logic [2:0]  rd_id_o;
    logic [31:0] rd_taken_o, rd_raised_o, rd_latency_o, rd_gap_o;
    logic        rd_valid_o;
    logic [CNT_W-1:0] accept_cnt_o;

    irq_history_log #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .cycle_i(cycle_i), .raise_i(raise_i),
        .take_i(take_i), .take_id_i(take_id_i), .rd_pos_i(rd_pos_i),
        .rd_id_o(rd_id_o), .rd_taken_o(rd_taken_o), .rd_raised_o(rd_raised_o),
        .rd_valid_o(rd_valid_o), .rd_latency_o(rd_latency_o),
        .rd_gap_o(rd_gap_o), .accept_cnt_o(accept_cnt_o)
    );

    always #(PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0]      cyc;
    logic [31:0]      m_stamp  [8];
    logic [2:0]       m_id     [DEPTH];
    logic [31:0]      m_taken  [DEPTH];
    logic [31:0]      m_raised [DEPTH];
    logic [3:0]       m_head;
    logic [CNT_W-1:0] m_cnt;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 8; i++) m_stamp[i] = '0;
        for (int i = 0; i < DEPTH; i++) begin
            m_id[i] = '0; m_taken[i] = '0; m_raised[i] = '0;
        end
        m_head = '0;
        m_cnt  = '0;
    endtask

    // Called at a negedge; returns at the following negedge
    task automatic tick(logic [7:0] r, logic t, logic [2:0] id);
        raise_i   = r;
        take_i    = t;
        take_id_i = id;
        cycle_i   = cyc;
        @(posedge clk);
        if (t) begin
            m_id[m_head]     = id;
            m_taken[m_head]  = cyc;
            m_raised[m_head] = m_stamp[id];
            m_head           = m_head + 1'b1;
            m_cnt            = m_cnt + 1'b1;
        end
        for (int i = 0; i < 8; i++) if (r[i]) m_stamp[i] = cyc;
        @(negedge clk);
        raise_i = '0;
        take_i  = 1'b0;
        cyc     = cyc + 1;
    endtask

    task automatic check_pos(string tag, int k);
        logic [3:0]  s, o;
        logic        v, ov;
        logic [31:0] lat, gap;
        rd_pos_i = 4'(k);
        #1;
        s   = m_head - 4'(k) - 4'd1;
        o   = s - 4'd1;
        v   = (m_taken[s] != 0);
        ov  = (k != DEPTH-1) && (m_taken[o] != 0);
        lat = v ? m_taken[s] - m_raised[s] : 32'd0;
        gap = (v && ov) ? m_taken[s] - m_taken[o] : 32'd0;
        chk({tag, " R6"}, "id",     64'(rd_id_o),     64'(m_id[s]));
        chk({tag, " R6"}, "taken",  64'(rd_taken_o),  64'(m_taken[s]));
        chk({tag, " R2"}, "raised", 64'(rd_raised_o), 64'(m_raised[s]));
        chk({tag, " R7"}, "valid",  64'(rd_valid_o),  64'(v));
        chk({tag, " R8"}, "latency", 64'(rd_latency_o), 64'(lat));
        chk({tag, " R9"}, "gap",    64'(rd_gap_o),    64'(gap));
    endtask

    task automatic check_all(string tag);
        for (int k = 0; k < DEPTH; k++) check_pos(tag, k);
        chk({tag, " R4"}, "count", 64'(accept_cnt_o), 64'(m_cnt));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] old_stamp;
        logic [CNT_W-1:0] cnt_before;
        raise_i = '0; take_i = 1'b0; take_id_i = '0; rd_pos_i = '0;
        cycle_i = 32'd1;
        cyc     = 32'd1;
        rst     = 1'b1;
        model_clear();
        @(negedge clk);
        do_reset();

        // R5: reset state, R7: empty history reads invalid everywhere
        check_all("reset R5");
        rd_pos_i = '0; #1;
        chk("R7", "valid after reset", 64'(rd_valid_o), 64'd0);

        // Table walk: R1 stamping and R2/R6 newest entry after each step
        for (int v = 0; v < NVEC; v++) begin
            tick(VEC[v][11:4], VEC[v][3], VEC[v][2:0]);
            check_pos("table R1", 0);
            chk("R4", "count", 64'(accept_cnt_o), 64'(m_cnt));
        end
        check_all("table");

        // R2: same-cycle raise and accept of line 6 uses the older stamp
        tick(8'b0100_0000, 1'b0, 3'd0);
        old_stamp = cyc - 1;
        tick(8'b0000_0000, 1'b0, 3'd0);
        tick(8'b0100_0000, 1'b1, 3'd6);
        rd_pos_i = '0; #1;
        chk("R2", "raised on same-cycle raise", 64'(rd_raised_o), 64'(old_stamp));
        chk("R8", "latency on same-cycle raise", 64'(rd_latency_o), 64'(cyc - 1 - old_stamp));
        check_all("same cycle R2");

        // R10: raises without accept leave log and count unchanged
        for (int i = 0; i < 5; i++) tick(8'hFF, 1'b0, 3'd1);
        check_all("idle R10");

        // R3: overfill the ring so it wraps and overwrites the oldest entries
        for (int i = 0; i < DEPTH + 5; i++) begin
            tick(8'(1 << (i % 8)), 1'b1, 3'(i % 8));
        end
        check_all("wrap R3");
        rd_pos_i = 4'(DEPTH - 1); #1;
        chk("R9", "gap at last position", 64'(rd_gap_o), 64'd0);

        // R5: reset in the middle of a run clears everything
        do_reset();
        check_all("mid reset R5");

        // R7/R9: partial history, positions past it are invalid
        tick(8'b0000_1000, 1'b0, 3'd0);
        tick(8'b0000_0000, 1'b1, 3'd3);
        tick(8'b0000_0000, 1'b0, 3'd0);
        tick(8'b0000_0000, 1'b1, 3'd3);
        rd_pos_i = 4'd1; #1;
        chk("R9", "gap to invalid older", 64'(rd_gap_o), 64'd0);
        rd_pos_i = 4'd2; #1;
        chk("R7", "valid past history", 64'(rd_valid_o), 64'd0);
        check_all("partial R7");

        // R4: counter wraps modulo 2^CNT_W
        cnt_before = accept_cnt_o;
        for (int i = 0; i < (1 << CNT_W); i++) tick(8'h00, 1'b1, 3'(i % 8));
        chk("R4", "count after full wrap", 64'(accept_cnt_o), 64'(cnt_before));
        check_all("count wrap R4");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule